// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is the coherence controller for one processor's private cache on a plain shared bus that has no shared-line signal. It holds a small direct-mapped array with a tag, a single data word and a four-value state per set. The states are Invalid, Valid, Reserved and Dirty.

The processor side takes one read or write at a time and reports completion with a one-cycle done pulse. On the bus side the controller masters read, read-with-intent-to-modify and memory-write transactions. It also watches the transactions of the other caches through a snoop port.

The coherence policy is write-once. The first write to a Valid line goes through to memory, which tells every other cache to drop its copy, and the local line becomes Reserved. Later writes stay in the cache and make the line Dirty. A Dirty line is written back to memory when it is replaced. On a snooped read, only a Dirty holder supplies the data.

Top module: `wo_cache`

## Requirements
- R1: After reset every set is Invalid, `bus_valid` and `cpu_done` are low, and the first access to any address misses.
- R2: A read miss issues one bus read (op code 0) at the request address. It installs the returned word as Valid, returns it on `cpu_rdata` and pulses `cpu_done`, which only follows an accepted request.
- R3: A read hit returns the cached word with no bus transaction, and `cpu_done` rises one cycle after the request is sampled. `cpu_done` never stays high for two cycles in a row.
- R4: A write hit on a Valid line issues exactly one memory write (op code 3) carrying the new data at the line address, and leaves the line Reserved.
- R5: A write hit on a Reserved or Dirty line updates only the cache, with no bus transaction, and leaves the line Dirty.
- R6: A write miss issues one read-with-intent-to-modify (op code 1) and then merges the write data locally. Memory is not written and the line ends Dirty.
- R7: A bus request keeps its op, address and data stable until `bus_ack`. Replacing a Dirty line first writes the victim word back (op 3 at the victim address), then fetches the new line. Replacing a Valid or Reserved line issues no write-back.
- R8: A snooped read (op 0) that hits a Dirty line raises `snp_intervene` in the same cycle with the line data on `snp_data`. Memory is assumed to capture that word. A snooped read that hits a Dirty or Reserved line demotes it to Valid, so the next local write goes through to memory again.
- R9: `snp_intervene` stays low for a snoop that hits a Valid or Reserved line, and for a snoop whose set is Invalid.
- R10: A snooped read-with-intent-to-modify (op 1), invalidate (op 2) or memory write (op 3) that hits a line makes it Invalid. A hit on a Dirty line by op 1 also intervenes.
- R11: A snoop whose tag differs from the stored tag of its set leaves that line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the low IDX_W bits select the set |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_valid | output | 1 | Bus request outstanding |
| bus_op | output | 2 | 0 read, 1 read-with-intent-to-modify, 3 memory write |
| bus_addr | output | ADDR_W | Bus request address |
| bus_wdata | output | DATA_W | Data for memory writes |
| bus_ack | input | 1 | One-cycle completion of the bus request |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_ack` |
| snp_valid | input | 1 | Snooped transaction present this cycle |
| snp_op | input | 2 | Snooped op code: 0 read, 1 read-with-intent-to-modify, 2 invalidate, 3 write |
| snp_addr | input | ADDR_W | Snooped address |
| snp_intervene | output | 1 | This cache supplies the data for the snooped transaction |
| snp_data | output | DATA_W | Intervention data |

## Verification
The bench builds the block with its defaults: 8-bit addresses, 8-bit data and four sets. With only four sets, two addresses 16 apart share a set. Directed sequences can therefore force a Dirty victim, a clean victim and a tag mismatch within a handful of accesses. The bench cannot read a line's state directly, so it infers the state from what the controller puts on the bus next. A write that produces a memory write shows the line was Valid, and a write that produces nothing shows it was Reserved or Dirty. A read that produces a bus read shows the line had been invalidated.

// File: rtl/wo_pkg.sv
package wo_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_V = 2'd1,
        ST_R = 2'd2,
        ST_D = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_RWITM = 2'd1,
        OP_INV   = 2'd2,
        OP_WR    = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_WT   = 2'd1,
        F_CB   = 2'd2,
        F_FILL = 2'd3
    } fsm_e;

    // State a held line takes after another master's transaction hits it.
    function automatic line_st_e snoop_next(line_st_e s, bus_op_e op);
        if (op == OP_RD)
            return (s == ST_D || s == ST_R) ? ST_V : s;
        return ST_I;
    endfunction

    // Only a dirty owner provides data to a reader.
    function automatic logic must_supply(line_st_e s, bus_op_e op);
        return (s == ST_D) && (op == OP_RD || op == OP_RWITM);
    endfunction

    function automatic logic is_owned(line_st_e s);
        return (s == ST_R) || (s == ST_D);
    endfunction

endpackage

// File: rtl/wo_line_store.sv
module wo_line_store
    import wo_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sn_en,
    input  logic [IDX_W-1:0]  sn_idx,
    input  line_st_e          sn_st
);

    line_st_e          st_q   [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    genvar g;
    generate
        for (g = 0; g < SETS; g++) begin : g_set
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q[g] <= ST_I;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    st_q[g] <= wr_st;
                end else if (sn_en && sn_idx == IDX_W'(g)) begin
                    st_q[g] <= sn_st;
                end
            end

            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    tag_q[g]  <= wr_tag;
                    data_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    // R1: the cycle after reset, every set reads back Invalid on port a
    a_r1_reset_invalid: assert property (@(posedge clk)
        $fell(rst) |-> a_st == ST_I);

endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
    import wo_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              intervene,
    output logic [DATA_W-1:0] supply_data,
    output logic              upd_en,
    output line_st_e          upd_st
);

    bus_op_e op;
    logic    hit;

    assign op          = bus_op_e'(snp_op);
    assign hit         = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    assign intervene   = hit && must_supply(line_st, op);
    assign supply_data = line_data;
    assign upd_st      = snoop_next(line_st, op);
    assign upd_en      = hit && (upd_st != line_st);

    // R9: a clean or absent line never drives data onto the bus
    a_r9_clean_never_supplies: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && line_st != ST_D) |-> !intervene);

endmodule

// File: rtl/wo_cache.sv
module wo_cache
    import wo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SETS   = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_valid,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_intervene,
    output logic [DATA_W-1:0] snp_data
);

    fsm_e              fsm;
    logic              rq_we;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;

    line_st_e          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_e          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              sn_en;
    line_st_e          sn_st;

    logic [IDX_W-1:0]  cpu_idx;
    logic [TAG_W-1:0]  cpu_tag;
    logic              accept, hit;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign accept  = (fsm == F_IDLE) && cpu_req && !cpu_done;
    assign hit     = (a_st != ST_I) && (a_tag == cpu_tag);

    wo_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .a_idx  (cpu_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .b_idx  (snp_addr[IDX_W-1:0]),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_st  (wr_st),
        .wr_tag (wr_tag),
        .wr_data(wr_data),
        .sn_en  (sn_en),
        .sn_idx (snp_addr[IDX_W-1:0]),
        .sn_st  (sn_st)
    );

    wo_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .clk        (clk),
        .rst        (rst),
        .snp_valid  (snp_valid),
        .snp_op     (snp_op),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .line_st    (b_st),
        .line_tag   (b_tag),
        .line_data  (b_data),
        .intervene  (snp_intervene),
        .supply_data(snp_data),
        .upd_en     (sn_en),
        .upd_st     (sn_st)
    );

    // Local array updates: hits in copy-back mode, write-through completion, fill.
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = rq_addr[IDX_W-1:0];
        wr_tag  = rq_addr[ADDR_W-1:IDX_W];
        wr_st   = ST_I;
        wr_data = rq_wdata;
        case (fsm)
            F_IDLE: if (accept && cpu_we && hit && is_owned(a_st)) begin
                wr_en   = 1'b1;
                wr_idx  = cpu_idx;
                wr_tag  = cpu_tag;
                wr_st   = ST_D;
                wr_data = cpu_wdata;
            end
            F_WT: if (bus_ack) begin
                wr_en = 1'b1;
                wr_st = ST_R;
            end
            F_FILL: if (bus_ack) begin
                wr_en   = 1'b1;
                wr_st   = rq_we ? ST_D : ST_V;
                wr_data = rq_we ? rq_wdata : bus_rdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm       <= F_IDLE;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
            bus_valid <= 1'b0;
            bus_op    <= OP_RD;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rq_we     <= 1'b0;
            rq_addr   <= '0;
            rq_wdata  <= '0;
        end else begin
            cpu_done <= 1'b0;
            case (fsm)
                F_IDLE: if (accept) begin
                    rq_we    <= cpu_we;
                    rq_addr  <= cpu_addr;
                    rq_wdata <= cpu_wdata;
                    if (hit && !cpu_we) begin
                        cpu_rdata <= a_data;
                        cpu_done  <= 1'b1;
                    end else if (hit && is_owned(a_st)) begin
                        cpu_done <= 1'b1;
                    end else if (hit) begin
                        bus_valid <= 1'b1;
                        bus_op    <= OP_WR;
                        bus_addr  <= cpu_addr;
                        bus_wdata <= cpu_wdata;
                        fsm       <= F_WT;
                    end else if (a_st == ST_D) begin
                        bus_valid <= 1'b1;
                        bus_op    <= OP_WR;
                        bus_addr  <= {a_tag, cpu_idx};
                        bus_wdata <= a_data;
                        fsm       <= F_CB;
                    end else begin
                        bus_valid <= 1'b1;
                        bus_op    <= cpu_we ? OP_RWITM : OP_RD;
                        bus_addr  <= cpu_addr;
                        bus_wdata <= '0;
                        fsm       <= F_FILL;
                    end
                end
                F_WT: if (bus_ack) begin
                    bus_valid <= 1'b0;
                    cpu_done  <= 1'b1;
                    fsm       <= F_IDLE;
                end
                F_CB: if (bus_ack) begin
                    bus_op    <= rq_we ? OP_RWITM : OP_RD;
                    bus_addr  <= rq_addr;
                    bus_wdata <= '0;
                    fsm       <= F_FILL;
                end
                F_FILL: if (bus_ack) begin
                    bus_valid <= 1'b0;
                    cpu_done  <= 1'b1;
                    if (!rq_we) cpu_rdata <= bus_rdata;
                    fsm       <= F_IDLE;
                end
                default: fsm <= F_IDLE;
            endcase
        end
    end

    // R3: completion is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    // R2: a completion only follows a processor request
    a_r2_done_needs_request: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_done) |-> $past(cpu_req));

    // R7: an outstanding bus request holds still until acknowledged
    a_r7_bus_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ack) |=>
            (bus_valid && $stable(bus_op) && $stable(bus_addr) && $stable(bus_wdata)));

    // R5: a write hit on an owned line finishes locally without a bus request
    a_r5_local_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (accept && cpu_we && hit && is_owned(a_st)) |=> (!bus_valid && cpu_done));

endmodule

// File: tb/wo_cache_bench.sv
`timescale 1ns/1ps
module wo_cache_bench;

    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata;
    logic          cpu_done;
    logic          bus_valid, bus_ack;
    logic [1:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid, snp_intervene;
    logic [1:0]    snp_op;
    logic [AW-1:0] snp_addr;
    logic [DW-1:0] snp_data;

    always #2.5 clk = ~clk;

    wo_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) u_wo_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_intervene(snp_intervene), .snp_data(snp_data)
    );

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem [256];
    logic [1:0]    lg_op   [8];
    logic [AW-1:0] lg_addr [8];
    logic [DW-1:0] lg_data [8];
    int            lg_n;

    function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
        return a ^ 8'hA5;
    endfunction

    // Behavioural memory: acknowledges each request one cycle after it appears.
    always @(negedge clk) begin
        if (bus_valid && !bus_ack) begin
            if (lg_n < 8) begin
                lg_op[lg_n]   = bus_op;
                lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_wdata;
            end
            lg_n = lg_n + 1;
            if (bus_op == 2'd3) mem[bus_addr] = bus_wdata;
            else bus_rdata = mem[bus_addr];
            bus_ack = 1'b1;
        end else begin
            bus_ack = 1'b0;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int ops, output int cyc);
        @(negedge clk);
        lg_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_done && cyc < 50);
        cpu_req = 1'b0;
        rd  = cpu_rdata;
        ops = lg_n;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a,
                         output logic iv, output logic [DW-1:0] dv);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        #1;
        iv = snp_intervene;
        dv = snp_data;
        if (iv) mem[a] = dv;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset_and_read_miss();
        logic [DW-1:0] rd; int ops, cyc;
        chk(cpu_done == 1'b0, "R1 done low after reset", cpu_done, 0);
        chk(bus_valid == 1'b0, "R1 bus idle after reset", bus_valid, 0);
        cpu_op(1'b0, 8'h10, 8'h00, rd, ops, cyc);
        chk(ops == 1 && lg_op[0] == 2'd0 && lg_addr[0] == 8'h10, "R1 R2 miss issues bus read",
            ops, 1);
        chk(rd == init_val(8'h10), "R2 miss data", rd, init_val(8'h10));
    endtask

    task automatic t_read_hit();
        logic [DW-1:0] rd; int ops, cyc;
        cpu_op(1'b0, 8'h10, 8'h00, rd, ops, cyc);
        chk(ops == 0, "R3 read hit no bus", ops, 0);
        chk(rd == init_val(8'h10), "R3 read hit data", rd, init_val(8'h10));
        chk(cyc == 1, "R3 read hit latency", cyc, 1);
    endtask

    task automatic t_write_once();
        logic [DW-1:0] rd; int ops, cyc;
        cpu_op(1'b1, 8'h10, 8'h77, rd, ops, cyc);
        chk(ops == 1 && lg_op[0] == 2'd3 && lg_addr[0] == 8'h10 && lg_data[0] == 8'h77,
            "R4 first write goes through", ops, 1);
        chk(mem[8'h10] == 8'h77, "R4 memory updated", mem[8'h10], 8'h77);
        cpu_op(1'b1, 8'h10, 8'h78, rd, ops, cyc);
        chk(ops == 0, "R5 write on Reserved stays local", ops, 0);
        cpu_op(1'b1, 8'h10, 8'h79, rd, ops, cyc);
        chk(ops == 0, "R5 write on Dirty stays local", ops, 0);
        chk(mem[8'h10] == 8'h77, "R5 memory untouched", mem[8'h10], 8'h77);
        cpu_op(1'b0, 8'h10, 8'h00, rd, ops, cyc);
        chk(rd == 8'h79 && ops == 0, "R5 local data visible", rd, 8'h79);
    endtask

    task automatic t_evictions();
        logic [DW-1:0] rd; int ops, cyc;
        cpu_op(1'b0, 8'h20, 8'h00, rd, ops, cyc);
        chk(ops == 2 && lg_op[0] == 2'd3 && lg_addr[0] == 8'h10 && lg_data[0] == 8'h79,
            "R7 dirty victim copied back", ops, 2);
        chk(lg_op[1] == 2'd0 && lg_addr[1] == 8'h20, "R7 fill after copy-back", lg_addr[1], 8'h20);
        chk(rd == init_val(8'h20), "R7 fill data", rd, init_val(8'h20));
        cpu_op(1'b0, 8'h30, 8'h00, rd, ops, cyc);
        chk(ops == 1 && lg_op[0] == 2'd0, "R7 clean victim no copy-back", ops, 1);
    endtask

    task automatic t_write_miss();
        logic [DW-1:0] rd; int ops, cyc;
        cpu_op(1'b1, 8'h41, 8'h33, rd, ops, cyc);
        chk(ops == 1 && lg_op[0] == 2'd1 && lg_addr[0] == 8'h41, "R6 write miss issues RWITM",
            lg_op[0], 1);
        chk(mem[8'h41] == init_val(8'h41), "R6 memory not written", mem[8'h41], init_val(8'h41));
        cpu_op(1'b1, 8'h41, 8'h34, rd, ops, cyc);
        chk(ops == 0, "R6 line ends Dirty", ops, 0);
    endtask

    task automatic t_snoop_reads();
        logic [DW-1:0] rd, dv; int ops, cyc; logic iv;
        snoop(2'd0, 8'h41, iv, dv);
        chk(iv == 1'b1 && dv == 8'h34, "R8 dirty line intervenes", dv, 8'h34);
        cpu_op(1'b1, 8'h41, 8'h35, rd, ops, cyc);
        chk(ops == 1 && lg_op[0] == 2'd3, "R8 dirty demoted to Valid", ops, 1);
        snoop(2'd0, 8'h41, iv, dv);
        chk(iv == 1'b0, "R9 reserved line no intervention", iv, 0);
        cpu_op(1'b1, 8'h41, 8'h36, rd, ops, cyc);
        chk(ops == 1 && lg_data[0] == 8'h36, "R8 reserved demoted to Valid", ops, 1);
        snoop(2'd0, 8'h30, iv, dv);
        chk(iv == 1'b0, "R9 valid line no intervention", iv, 0);
        snoop(2'd0, 8'h43, iv, dv);
        chk(iv == 1'b0, "R9 invalid set no intervention", iv, 0);
        cpu_op(1'b0, 8'h30, 8'h00, rd, ops, cyc);
        chk(ops == 0, "R9 snooped read keeps Valid", ops, 0);
    endtask

    task automatic t_snoop_kills();
        logic [DW-1:0] rd, dv; int ops, cyc; logic iv;
        snoop(2'd2, 8'h70, iv, dv);
        cpu_op(1'b0, 8'h30, 8'h00, rd, ops, cyc);
        chk(ops == 0, "R11 tag mismatch ignored", ops, 0);
        snoop(2'd2, 8'h30, iv, dv);
        cpu_op(1'b0, 8'h30, 8'h00, rd, ops, cyc);
        chk(ops == 1 && lg_op[0] == 2'd0, "R10 invalidate drops line", ops, 1);
        snoop(2'd3, 8'h30, iv, dv);
        cpu_op(1'b0, 8'h30, 8'h00, rd, ops, cyc);
        chk(ops == 1, "R10 snooped write drops line", ops, 1);
        cpu_op(1'b1, 8'h42, 8'h5C, rd, ops, cyc);
        snoop(2'd1, 8'h42, iv, dv);
        chk(iv == 1'b1 && dv == 8'h5C, "R10 RWITM on dirty intervenes", dv, 8'h5C);
        cpu_op(1'b0, 8'h42, 8'h00, rd, ops, cyc);
        chk(ops == 1 && rd == 8'h5C, "R10 RWITM drops line", ops, 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));
        lg_n = 0; bus_ack = 1'b0; bus_rdata = '0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        snp_valid = 1'b0; snp_op = 2'd0; snp_addr = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_read_miss();
        t_read_hit();
        t_write_once();
        t_evictions();
        t_write_miss();
        t_snoop_reads();
        t_snoop_kills();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule